// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block turns a pixel clock into the raster timing of a display. It holds a horizontal and a vertical pixel counter. For each axis, three programmable windows (active region, blanking, sync) are compared against the counter, and the results drive `hsync`, `vsync`, `blank` and `de`.

Software programs the block through a single-cycle register bus with address, write data, write strobe and combinational read data. Each timing register packs two 16-bit fields. The low half is the start field (or the last active pixel) and the high half is the end field (or the last pixel of the line or frame). Both are stored as the real count minus one.

Every register except the lock register is write-protected. Writes take effect only while the block is unlocked with a key. The usual sequence to change a mode is:
1. Unlock the registers.
2. Clear the run bit.
3. Write the six timing words and the pitch.
4. Set the run bit again.
5. Relock the registers.

A configuration word carries the run bit, graphics and video enables, and a pixel format code. These enables and the format code are passed to downstream logic.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the block is locked, every register reads zero, both counters are zero, `hsync`, `vsync` and `de` are low, and `blank` is high.
- R2: A write to address 0 unlocks the block when its low 16 bits equal 16'h4758, and relocks it for any other value. Reading address 0 returns the unlock state in bit 0 and zero in all other bits.
- R3: While the block is locked, writes to addresses 1 to 8 change no register and no output.
- R4: Register map and read-back:
  - Address 2 holds a 16-bit line pitch in units of 8 bytes.
  - Addresses 3, 4 and 5 hold the horizontal active/total, blank and sync words.
  - Addresses 6, 7 and 8 hold the vertical active/total, blank and sync words.
  - Each timing word has the start field in bits 15:0 and the end field in bits 31:16, and reads back the full 32 bits.
  - Addresses 9 to 15 read zero and ignore writes.
- R5: The configuration word at address 1 has the following bits: bit 0 run, bit 1 graphics enable, bit 2 video enable, bits 5:4 pixel format. Bit 3 and bits 31:6 read zero. While run is 0, both counters are held at zero, `hsync`, `vsync` and `de` are low, and `blank` is high.
- R6: While run is 1, the horizontal counter advances by one per clock. In the cycle after it reaches or exceeds the horizontal end field of address 3, it returns to zero.
- R7: The vertical counter advances by one only in cycles where the horizontal counter wraps. It returns to zero on a wrap where it is at or above the vertical end field of address 6.
- R8: `hsync` is high while run is 1 and the horizontal counter is greater than the start field and not greater than the end field of address 5. `vsync` follows the same rule with the vertical counter and address 8.
- R9: `blank` is high when either counter is greater than the start field and not greater than the end field of its blank word (addresses 4 and 7).
- R10: `de` is high when run is 1, the horizontal counter is not greater than the start field of address 3, and the vertical counter is not greater than the start field of address 6.
- R11: `gfx_en`, `vid_en` and `pix_fmt` follow configuration bits 1, 2 and 5:4 regardless of run. The format codes are 0 for 8 bits per pixel, 1 for 16 and 2 for 24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| hcount | output | 16 | Horizontal pixel counter |
| vcount | output | 16 | Vertical line counter |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | Blanking interval |
| de | output | 1 | Display enable, pixel is visible |
| gfx_en | output | 1 | Graphics enable from configuration |
| vid_en | output | 1 | Video enable from configuration |
| pix_fmt | output | 2 | Pixel format code from configuration |

## Verification
The bench keeps the default 16-bit fields, 4-bit address and 32-bit data. It programs two tiny modes: a 17-by-9 raster and an 8-by-6 raster. With these sizes, every sync, blank and wrap edge recurs many times within a few hundred clocks. The vertical wrap, the hold at zero while run is clear, and a timing word shrunk below the running counter all lie within reach of a short run. Period checks on `hsync` and `vsync` are done alongside a per-clock comparison against a behavioural model.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    localparam int FIELD_W = 16;
    localparam int DATA_W  = 2 * FIELD_W;
    localparam int ADDR_W  = 4;
    localparam int AXES    = 2;
    localparam logic [FIELD_W-1:0] UNLOCK_KEY = 16'h4758;

    typedef enum logic [ADDR_W-1:0] {
        A_LOCK  = 4'd0,
        A_CFG   = 4'd1,
        A_PITCH = 4'd2,
        A_H_ACT = 4'd3,
        A_H_BLK = 4'd4,
        A_H_SYN = 4'd5,
        A_V_ACT = 4'd6,
        A_V_BLK = 4'd7,
        A_V_SYN = 4'd8
    } reg_addr_e;

    typedef struct packed {
        logic [FIELD_W-1:0] hi;
        logic [FIELD_W-1:0] lo;
    } win_t;

    typedef struct packed {
        win_t syn;
        win_t blk;
        win_t act;
    } axis_tim_t;

    typedef struct packed {
        logic [1:0] fmt;
        logic       vid;
        logic       gfx;
        logic       run;
    } cfg_t;

    typedef struct packed {
        logic                  unlocked;
        cfg_t                  cfg;
        logic [FIELD_W-1:0]    pitch;
        axis_tim_t [AXES-1:0]  tim;
    } rf_t;
endpackage

// File: rtl/rtg_regfile.sv
module rtg_regfile
    import rtg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    input  logic                  we,
    output logic [DW-1:0]         rdata,
    output cfg_t                  cfg,
    output axis_tim_t [AXES-1:0]  tim
);
    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (we) begin
            if (addr == A_LOCK) begin
                rf_d.unlocked = (wdata[FIELD_W-1:0] == UNLOCK_KEY);
            end else if (rf_q.unlocked) begin
                case (addr)
                    A_CFG:   rf_d.cfg = '{fmt: wdata[5:4], vid: wdata[2],
                                          gfx: wdata[1], run: wdata[0]};
                    A_PITCH: rf_d.pitch = wdata[FIELD_W-1:0];
                    A_H_ACT: rf_d.tim[0].act = wdata;
                    A_H_BLK: rf_d.tim[0].blk = wdata;
                    A_H_SYN: rf_d.tim[0].syn = wdata;
                    A_V_ACT: rf_d.tim[1].act = wdata;
                    A_V_BLK: rf_d.tim[1].blk = wdata;
                    A_V_SYN: rf_d.tim[1].syn = wdata;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_LOCK:  rdata[0] = rf_q.unlocked;
            A_CFG:   rdata[5:0] = {rf_q.cfg.fmt, 1'b0, rf_q.cfg.vid,
                                   rf_q.cfg.gfx, rf_q.cfg.run};
            A_PITCH: rdata[FIELD_W-1:0] = rf_q.pitch;
            A_H_ACT: rdata = rf_q.tim[0].act;
            A_H_BLK: rdata = rf_q.tim[0].blk;
            A_H_SYN: rdata = rf_q.tim[0].syn;
            A_V_ACT: rdata = rf_q.tim[1].act;
            A_V_BLK: rdata = rf_q.tim[1].blk;
            A_V_SYN: rdata = rf_q.tim[1].syn;
            default: rdata = '0;
        endcase
    end

    assign cfg = rf_q.cfg;
    assign tim = rf_q.tim;

    AST_LOCKED_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr != A_LOCK && !rf_q.unlocked) |=>
            ($stable(rf_q.cfg) && $stable(rf_q.pitch) && $stable(rf_q.tim))); // R3
    AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_LOCK && wdata[FIELD_W-1:0] == UNLOCK_KEY) |=> rf_q.unlocked); // R2
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis
    import rtg_pkg::*;
#(
    parameter int W = FIELD_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           step,
    input  axis_tim_t      tim,
    output logic [W-1:0]   count,
    output logic           wrap,
    output logic           in_act,
    output logic           in_blk,
    output logic           in_syn
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } axis_st_t;

    axis_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = run && step && (st_q.cnt >= tim.act.hi);
        if (!run)       st_d.cnt = '0;
        else if (wrap)  st_d.cnt = '0;
        else if (step)  st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count  = st_q.cnt;
    assign in_act = (st_q.cnt <= tim.act.lo);
    assign in_blk = (st_q.cnt > tim.blk.lo) && (st_q.cnt <= tim.blk.hi);
    assign in_syn = (st_q.cnt > tim.syn.lo) && (st_q.cnt <= tim.syn.hi);

    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (count == '0)); // R5
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == '0)); // R6
    AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step && !wrap) |=> (count == $past(count) + 1'b1)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !step) |=> $stable(count)); // R7
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int CW = FIELD_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    input  logic           bus_we,
    output logic [DW-1:0]  bus_rdata,
    output logic [CW-1:0]  hcount,
    output logic [CW-1:0]  vcount,
    output logic           hsync,
    output logic           vsync,
    output logic           blank,
    output logic           de,
    output logic           gfx_en,
    output logic           vid_en,
    output logic [1:0]     pix_fmt
);
    cfg_t                 cfg;
    axis_tim_t [AXES-1:0] tim;
    logic [AXES-1:0]      step, wrap, in_act, in_blk, in_syn;
    logic [CW-1:0]        cnt [AXES];

    rtg_regfile #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
        .we(bus_we), .rdata(bus_rdata), .cfg(cfg), .tim(tim)
    );

    for (genvar g = 0; g < AXES; g++) begin : g_axis
        if (g == 0) begin : g_first
            assign step[g] = 1'b1;
        end else begin : g_chain
            assign step[g] = wrap[g-1];
        end
        rtg_axis #(.W(CW)) u_axis (
            .clk(clk), .rst_n(rst_n), .run(cfg.run), .step(step[g]),
            .tim(tim[g]), .count(cnt[g]), .wrap(wrap[g]),
            .in_act(in_act[g]), .in_blk(in_blk[g]), .in_syn(in_syn[g])
        );
    end

    assign hcount  = cnt[0];
    assign vcount  = cnt[1];
    assign hsync   = cfg.run && in_syn[0];
    assign vsync   = cfg.run && in_syn[1];
    assign de      = cfg.run && (&in_act);
    assign blank   = !cfg.run || (|in_blk);
    assign gfx_en  = cfg.gfx;
    assign vid_en  = cfg.vid;
    assign pix_fmt = cfg.fmt;

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.run |-> (!hsync && !vsync && !de && blank)); // R5
    AST_V_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.run && !wrap[0]) |=> $stable(vcount)); // R7
endmodule

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [15:0] hcount, vcount;
    logic        hsync, vsync, blank, de, gfx_en, vid_en;
    logic [1:0]  pix_fmt;

    raster_timing_gen u_raster_timing_gen (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .hcount(hcount), .vcount(vcount),
        .hsync(hsync), .vsync(vsync), .blank(blank), .de(de),
        .gfx_en(gfx_en), .vid_en(vid_en), .pix_fmt(pix_fmt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;

    // behavioural model state
    bit          m_unl = 0;
    int unsigned m_cfg = 0;
    int unsigned m_pitch = 0;
    int unsigned m_reg [9] = '{default: 0};
    int unsigned m_h = 0, m_v = 0;

    function automatic int unsigned lo(int unsigned w); return w & 32'hFFFF; endfunction
    function automatic int unsigned hi(int unsigned w); return w >> 16; endfunction

    function automatic int unsigned m_read(int unsigned a);
        case (a)
            0: return {31'b0, m_unl};
            1: return m_cfg;
            2: return m_pitch;
            3, 4, 5, 6, 7, 8: return m_reg[a];
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_unl = 0; m_cfg = 0; m_pitch = 0; m_h = 0; m_v = 0;
            foreach (m_reg[i]) m_reg[i] = 0;
        end else begin
            if (m_cfg[0]) begin
                bit hw;
                hw = (m_h >= hi(m_reg[3]));
                m_h = hw ? 0 : m_h + 1;
                if (hw) m_v = (m_v >= hi(m_reg[6])) ? 0 : m_v + 1;
            end else begin
                m_h = 0; m_v = 0;
            end
            if (bus_we) begin
                if (bus_addr == 0) m_unl = (bus_wdata[15:0] == 16'h4758);
                else if (m_unl) begin
                    if (bus_addr == 1) m_cfg = bus_wdata & 32'h37;
                    else if (bus_addr == 2) m_pitch = bus_wdata & 32'hFFFF;
                    else if (bus_addr <= 8) m_reg[bus_addr] = bus_wdata;
                end
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            bit run;
            bit e_hs, e_vs, e_bl, e_de;
            run  = m_cfg[0];
            e_hs = run && m_h > lo(m_reg[5]) && m_h <= hi(m_reg[5]);
            e_vs = run && m_v > lo(m_reg[8]) && m_v <= hi(m_reg[8]);
            e_bl = !run || (m_h > lo(m_reg[4]) && m_h <= hi(m_reg[4]))
                        || (m_v > lo(m_reg[7]) && m_v <= hi(m_reg[7]));
            e_de = run && m_h <= lo(m_reg[3]) && m_v <= lo(m_reg[6]);
            check("R6", "hcount", hcount, m_h);
            check("R7", "vcount", vcount, m_v);
            check("R8", "hsync", hsync, e_hs);
            check("R8", "vsync", vsync, e_vs);
            check("R9", "blank", blank, e_bl);
            check("R10", "de", de, e_de);
            check("R11", "cfg outs", {gfx_en, vid_en, pix_fmt},
                  {m_cfg[1], m_cfg[2], m_cfg[5:4]});
            check("R4", "rdata", bus_rdata, m_read(bus_addr));
        end
    end

    // sync period measurement
    bit meas = 0;
    int hper_exp = 0, vper_exp = 0;
    int h_last = -1, v_last = -1;
    bit h_prev = 0, v_prev = 0;
    always @(negedge clk) begin
        if (meas) begin
            if (hsync && !h_prev) begin
                if (h_last >= 0) check("R8", "hsync period", cycles - h_last, hper_exp);
                h_last = cycles;
            end
            if (vsync && !v_prev) begin
                if (v_last >= 0) check("R8", "vsync period", cycles - v_last, vper_exp);
                v_last = cycles;
            end
        end else begin
            h_last = -1; v_last = -1;
        end
        h_prev = hsync; v_prev = vsync;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic wr(int unsigned a, int unsigned d);
        @(posedge clk); #1;
        bus_addr = a[3:0]; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd_check(int unsigned a, int unsigned exp, string req);
        @(posedge clk); #1;
        bus_addr = a[3:0];
        @(negedge clk);
        check(req, "readback", bus_rdata, exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        idle(3);
        @(negedge clk);
        // R1 reset state
        check("R1", "lock", bus_rdata, 0);
        check("R1", "outs", {hsync, vsync, de, blank}, 4'b0001);
        check("R1", "counts", {hcount, vcount}, 0);
        rst_n = 1'b1;
        idle(2);
        // R3 locked writes ignored
        wr(1, 32'h17);
        wr(3, 32'h0010_0007);
        rd_check(1, 0, "R3");
        rd_check(3, 0, "R3");
        check("R3", "hcount locked", hcount, 0);
        // R2 unlock by key in low half
        wr(0, 32'h1234_4758);
        rd_check(0, 1, "R2");
        // mode A: 17 x 9 raster
        wr(2, 32'hABCD_0050);
        rd_check(2, 32'h0050, "R4");
        wr(3, 32'h0010_0007); wr(4, 32'h0010_0007); wr(5, 32'h000C_0009);
        wr(6, 32'h0008_0003); wr(7, 32'h0008_0003); wr(8, 32'h0006_0004);
        rd_check(5, 32'h000C_0009, "R4");
        wr(1, 32'hFFFF_FF1F);
        rd_check(1, 32'h17, "R5");
        hper_exp = 17; vper_exp = 153; meas = 1;
        idle(400);
        meas = 0;
        // R2 relock with any other value, R3 ignored while running
        wr(0, 32'h4758_0000);
        rd_check(0, 0, "R2");
        wr(3, 32'h0003_0002);
        wr(1, 32'h0);
        rd_check(3, 32'h0010_0007, "R3");
        rd_check(1, 32'h17, "R3");
        meas = 1; idle(200); meas = 0;
        // R5 stop, hold at zero
        wr(0, 32'h0000_4758);
        wr(1, 32'h22);
        idle(5);
        @(negedge clk);
        check("R5", "counts off", {hcount, vcount}, 0);
        check("R5", "outs off", {hsync, vsync, de, blank}, 4'b0001);
        check("R11", "pix_fmt", pix_fmt, 2);
        // mode B: 8 x 6 raster
        wr(3, 32'h0007_0004); wr(4, 32'h0007_0004); wr(5, 32'h0006_0005);
        wr(6, 32'h0005_0002); wr(7, 32'h0005_0002); wr(8, 32'h0004_0003);
        wr(1, 32'h23);
        hper_exp = 8; vper_exp = 48; meas = 1;
        idle(150);
        meas = 0;
        // R6 shrink total below the running counter
        wr(3, 32'h0003_0002);
        idle(40);
        // R4 unmapped address
        wr(12, 32'hFFFF_FFFF);
        rd_check(12, 0, "R4");
        idle(5);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule